// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in ordinary memory. A requester presents the address, the access kind (read, write or instruction fetch), the privilege mode and the frame number of the top-level table. The walker then issues word reads on a simple memory port and follows the entries it reads. It answers with either a physical address plus the final entry's low attribute bits, or a fault with an error code.

A top-level entry may map a large region directly. When large mappings are enabled and the entry's size flag is set, the walk ends at the first level. After a walk succeeds, the walker marks each entry it used as accessed. On a write it also marks the final entry as dirty. Each marked entry goes back to memory only when its value actually changed.

Protection is enforced only for user-mode accesses. Supervisor accesses may write read-only pages. The walker serves one request at a time and holds `busy_o` high from the cycle after it accepts a request until its response.

Top module: `pt_walker`

## Requirements
- R1: The top-level entry is read from byte address {root_base_i, va[31:22], 2'b00}.
- R2: For a small mapping, the second-level entry is read from {top entry[31:12], va[21:12], 2'b00}. The physical address is {second entry[31:12], va[11:0]}.
- R3: If large_en_i is 1 and bit 7 of a present top-level entry is set, no second read is made and the physical address is {top entry[31:22], va[21:0]}. If large_en_i is 0, bit 7 is ignored and the walk goes on to the second level.
- R4: An entry with bit 0 (present) clear gives a fault with code bit 0 = 0, and no entry is written. A successful response carries code 0.
- R5: A user-mode access (req_user_i = 1) faults with code bit 0 = 1 unless bit 2 is set in every entry used.
- R6: A user-mode write faults with code bit 0 = 1 unless bit 1 is set in every entry used. A supervisor write to an entry with bit 1 clear succeeds.
- R7: On success, bit 5 is set in every entry used and bit 6 is set in the final entry on writes only. Write-backs go top entry first, then second entry, and only for entries whose value changes. A fault writes nothing.
- R8: Bits 11:9 of an entry do not affect the outcome and are kept in write-backs. rsp_attr_o returns bits 8:0 of the final entry after marking.
- R9: In the fault code, bit 1 is 1 for writes (req_acc_i = 1) and bit 2 is 1 for user mode. Bits 4:3 are always 0. A fetch (req_acc_i = 2) is checked like a read.
- R10: A request is accepted only while busy_o is 0. busy_o stays high until rsp_valid_o, which lasts one cycle. Requests offered while busy are ignored.
- R11: A memory operation keeps mem_valid_o, mem_we_o, mem_addr_o and mem_wdata_o stable until the cycle in which mem_ready_i is 1. Read data is taken in that cycle.
- R12: After reset, busy_o, mem_valid_o and rsp_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user_i | input | 1 | 1 = user mode, 0 = supervisor |
| root_base_i | input | 20 | Frame number of the top-level table |
| large_en_i | input | 1 | Allow large mappings at the first level |
| busy_o | output | 1 | Walk in progress |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_fault_o | output | 1 | Response is a fault |
| rsp_code_o | output | 5 | Fault code |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_attr_o | output | 9 | Final entry bits 8:0 after marking (0 on fault) |
| mem_valid_o | output | 1 | Memory operation valid |
| mem_we_o | output | 1 | Operation is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Operation completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |

## Verification
The walker is exercised with a range of table contents:
- small mappings, first touched and then touched again, which separate a write-back of a changed entry from a redundant one;
- a large entry walked with large mappings enabled and disabled, which shows whether the size flag is honoured or ignored;
- entries missing at either level, which separate not-present faults from protection faults;
- entries without the user or write permission, tried from both privilege modes and with all three access kinds, which expose a wrong fault-code bit or protection applied in supervisor mode;
- a second table root, which proves that the base input feeds the first address;
- requests held high during a walk, which must leave the operation sequence unchanged.

The memory answers after pseudo-random delays, so held operations are compared against the expected order of reads and writes.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int unsigned ENT_W  = 32;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned FRM_W  = ENT_W - OFS_W;
  localparam int unsigned LFRM_W = ENT_W - OFS_W - IDX_W;
  localparam int unsigned ESZ_W  = OFS_W - IDX_W;
  localparam int unsigned ATTR_W = 9;
  localparam int unsigned CODE_W = 5;

  localparam int unsigned BIT_P  = 0;
  localparam int unsigned BIT_RW = 1;
  localparam int unsigned BIT_US = 2;
  localparam int unsigned BIT_A  = 5;
  localparam int unsigned BIT_D  = 6;
  localparam int unsigned BIT_PS = 7;

  localparam int unsigned CB_PROT = 0;
  localparam int unsigned CB_WR   = 1;
  localparam int unsigned CB_USR  = 2;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_RD_TBL, S_WR_DIR, S_WR_TBL, S_DONE
  } walk_st_e;

  typedef struct packed {
    logic us;
    logic rw;
    logic p;
  } flg_t;
endpackage

// File: rtl/pt_walk_perm.sv
module pt_walk_perm
  import pt_walk_pkg::*;
(
  input  flg_t              dir_i,
  input  flg_t              tbl_i,
  input  logic              two_lvl_i,
  input  logic              is_write_i,
  input  logic              is_user_i,
  output logic              fault_o,
  output logic [CODE_W-1:0] code_o
);
  logic np, u_ok, w_ok, prot;

  always_comb begin
    np   = !dir_i.p || (two_lvl_i && !tbl_i.p);
    u_ok = dir_i.us && (!two_lvl_i || tbl_i.us);
    w_ok = dir_i.rw && (!two_lvl_i || tbl_i.rw);
    // rw only matters in user mode
    prot = !np && is_user_i && (!u_ok || (is_write_i && !w_ok));
    fault_o = np || prot;
    code_o = '0;
    code_o[CB_PROT] = prot;
    code_o[CB_WR]   = is_write_i;
    code_o[CB_USR]  = is_user_i;
  end
endmodule

// File: rtl/pt_walk_mark.sv
module pt_walk_mark
  import pt_walk_pkg::*;
(
  input  logic [ENT_W-1:0] ent_i,
  input  logic             set_dirty_i,
  output logic [ENT_W-1:0] new_o,
  output logic             changed_o
);
  always_comb begin
    new_o = ent_i;
    new_o[BIT_A] = 1'b1;
    if (set_dirty_i) new_o[BIT_D] = 1'b1;
    changed_o = (new_o != ent_i);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ENT_W-1:0]  req_vaddr_i,
  input  logic [1:0]        req_acc_i,
  input  logic              req_user_i,
  input  logic [FRM_W-1:0]  root_base_i,
  input  logic              large_en_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [CODE_W-1:0] rsp_code_o,
  output logic [ENT_W-1:0]  rsp_paddr_o,
  output logic [ATTR_W-1:0] rsp_attr_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ENT_W-1:0]  mem_addr_o,
  output logic [ENT_W-1:0]  mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [ENT_W-1:0]  mem_rdata_i
);
  walk_st_e          st_q;
  logic [ENT_W-1:0]  va_q, dir_q, tbl_q;
  logic [FRM_W-1:0]  base_q;
  logic              wr_q, usr_q, lgen_q, large_q;
  logic              fault_q;
  logic [CODE_W-1:0] code_q;
  logic [ENT_W-1:0]  paddr_q;
  logic [ATTR_W-1:0] attr_q;

  logic [ENT_W-1:0]  dir_addr, tbl_addr;
  flg_t              chk_dir, chk_tbl;
  logic              chk_two, chk_fault;
  logic [CODE_W-1:0] chk_code;

  logic [ENT_W-1:0]  mk_in  [2];
  logic [ENT_W-1:0]  mk_out [2];
  logic [1:0]        mk_dty, mk_chg;

  assign dir_addr = {base_q, va_q[ENT_W-1 -: IDX_W], {ESZ_W{1'b0}}};
  assign tbl_addr = {dir_q[ENT_W-1 -: FRM_W], va_q[OFS_W+IDX_W-1 -: IDX_W], {ESZ_W{1'b0}}};

  // one checker: first-level entry from the bus or from the register
  always_comb begin
    chk_two = (st_q == S_RD_TBL);
    chk_dir = chk_two ? flg_t'(dir_q[2:0]) : flg_t'(mem_rdata_i[2:0]);
    chk_tbl = flg_t'(mem_rdata_i[2:0]);
  end

  pt_walk_perm u_perm (
    .dir_i      (chk_dir),
    .tbl_i      (chk_tbl),
    .two_lvl_i  (chk_two),
    .is_write_i (wr_q),
    .is_user_i  (usr_q),
    .fault_o    (chk_fault),
    .code_o     (chk_code)
  );

  assign mk_in[0] = dir_q;
  assign mk_in[1] = tbl_q;
  assign mk_dty   = {wr_q, wr_q & large_q};

  for (genvar g = 0; g < 2; g++) begin : g_mark
    pt_walk_mark u_mark (
      .ent_i       (mk_in[g]),
      .set_dirty_i (mk_dty[g]),
      .new_o       (mk_out[g]),
      .changed_o   (mk_chg[g])
    );
  end

  always_comb begin
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = dir_addr;
    mem_wdata_o = '0;
    unique case (st_q)
      S_RD_DIR: mem_valid_o = 1'b1;
      S_RD_TBL: begin mem_valid_o = 1'b1; mem_addr_o = tbl_addr; end
      S_WR_DIR: begin
        mem_valid_o = mk_chg[0]; mem_we_o = 1'b1; mem_wdata_o = mk_out[0];
      end
      S_WR_TBL: begin
        mem_valid_o = mk_chg[1]; mem_we_o = 1'b1;
        mem_addr_o = tbl_addr; mem_wdata_o = mk_out[1];
      end
      default: ;
    endcase
  end

  assign busy_o      = (st_q != S_IDLE);
  assign rsp_valid_o = (st_q == S_DONE);
  assign rsp_fault_o = fault_q;
  assign rsp_code_o  = code_q;
  assign rsp_paddr_o = paddr_q;
  assign rsp_attr_o  = attr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      va_q <= '0; dir_q <= '0; tbl_q <= '0; base_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0; lgen_q <= 1'b0; large_q <= 1'b0;
      fault_q <= 1'b0; code_q <= '0; paddr_q <= '0; attr_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          va_q   <= req_vaddr_i;
          wr_q   <= (req_acc_i == ACC_WRITE);
          usr_q  <= req_user_i;
          base_q <= root_base_i;
          lgen_q <= large_en_i;
          st_q   <= S_RD_DIR;
        end
        S_RD_DIR: if (mem_ready_i) begin
          dir_q <= mem_rdata_i;
          if (!mem_rdata_i[BIT_P] || (lgen_q && mem_rdata_i[BIT_PS] && chk_fault)) begin
            fault_q <= 1'b1; code_q <= chk_code; paddr_q <= '0; attr_q <= '0;
            st_q <= S_DONE;
          end else if (lgen_q && mem_rdata_i[BIT_PS]) begin
            large_q <= 1'b1;
            st_q    <= S_WR_DIR;
          end else begin
            large_q <= 1'b0;
            st_q    <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (mem_ready_i) begin
          tbl_q <= mem_rdata_i;
          if (chk_fault) begin
            fault_q <= 1'b1; code_q <= chk_code; paddr_q <= '0; attr_q <= '0;
            st_q <= S_DONE;
          end else begin
            st_q <= S_WR_DIR;
          end
        end
        S_WR_DIR: if (!mk_chg[0] || mem_ready_i) begin
          if (large_q) begin
            fault_q <= 1'b0; code_q <= '0;
            paddr_q <= {dir_q[ENT_W-1 -: LFRM_W], va_q[OFS_W+IDX_W-1:0]};
            attr_q  <= mk_out[0][ATTR_W-1:0];
            st_q    <= S_DONE;
          end else begin
            st_q <= S_WR_TBL;
          end
        end
        S_WR_TBL: if (!mk_chg[1] || mem_ready_i) begin
          fault_q <= 1'b0; code_q <= '0;
          paddr_q <= {tbl_q[ENT_W-1 -: FRM_W], va_q[OFS_W-1:0]};
          attr_q  <= mk_out[1][ATTR_W-1:0];
          st_q    <= S_DONE;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [CODE_W-1:0] rsp_code_o,
  input logic [ATTR_W-1:0] rsp_attr_o,
  input logic              mem_valid_o,
  input logic              mem_we_o,
  input logic [ENT_W-1:0]  mem_addr_o,
  input logic [ENT_W-1:0]  mem_wdata_o,
  input logic              mem_ready_i
);
  localparam logic [ATTR_W-1:0] OK_MASK = ATTR_W'((1 << BIT_P) | (1 << BIT_A));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && !busy_o);

  p_busy_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(rsp_valid_o));

  p_code_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_code_o[CODE_W-1 -: 2] == 2'b00);

  p_ok_clean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_code_o == '0 && (rsp_attr_o & OK_MASK) == OK_MASK);

  p_wb_mark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_we_o |-> mem_wdata_o[BIT_A] && mem_wdata_o[BIT_P]);

  p_prot_user_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o && rsp_code_o[CB_PROT] |-> rsp_code_o[CB_USR]);
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  import pt_walk_pkg::*;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_user_i = 1'b0, large_en_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic [19:0] root_base_i = '0;
  logic        busy_o, rsp_valid_o, rsp_fault_o;
  logic [4:0]  rsp_code_o;
  logic [31:0] rsp_paddr_o;
  logic [8:0]  rsp_attr_o;
  logic        mem_valid_o, mem_we_o, mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;

  pt_walker dut (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  logic [31:0] mem     [4096];
  logic [31:0] ref_mem [4096];

  typedef struct packed {logic we; logic [31:0] addr; logic [31:0] data;} op_t;
  op_t exp_q[$];
  logic        exp_fault;
  logic [4:0]  exp_code;
  logic [31:0] exp_paddr;
  logic [8:0]  exp_attr;
  logic [7:0]  lfsr = 8'hA5;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int widx(input logic [31:0] a);
    return int'(a[13:2]);
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[widx(a)] = v;
    ref_mem[widx(a)] = v;
  endtask

  // behavioural reference: expected operation list and response
  task automatic model_walk(input logic [31:0] va, input logic [1:0] acc,
                            input bit user, input logic [19:0] base, input bit lgen);
    logic [31:0] pa, pd, pta, pt, npd, npt;
    bit wr;
    wr = (acc == 2'd1);
    pa = {base, 12'h000} + 32'(va[31:22]) * 4;
    pd = ref_mem[widx(pa)];
    exp_q.push_back('{1'b0, pa, 32'h0});
    exp_fault = 1'b0; exp_code = '0; exp_paddr = '0; exp_attr = '0;
    if (!pd[0]) begin
      exp_fault = 1'b1; exp_code = {2'b00, user, wr, 1'b0};
      return;
    end
    if (lgen && pd[7]) begin
      if (user && (!pd[2] || (wr && !pd[1]))) begin
        exp_fault = 1'b1; exp_code = {2'b00, user, wr, 1'b1};
        return;
      end
      npd = pd | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (npd != pd) begin exp_q.push_back('{1'b1, pa, npd}); ref_mem[widx(pa)] = npd; end
      exp_paddr = {pd[31:22], va[21:0]};
      exp_attr = npd[8:0];
      return;
    end
    pta = {pd[31:12], 12'h000} + 32'(va[21:12]) * 4;
    pt = ref_mem[widx(pta)];
    exp_q.push_back('{1'b0, pta, 32'h0});
    if (!pt[0]) begin
      exp_fault = 1'b1; exp_code = {2'b00, user, wr, 1'b0};
      return;
    end
    if (user && (!(pd[2] && pt[2]) || (wr && !(pd[1] && pt[1])))) begin
      exp_fault = 1'b1; exp_code = {2'b00, user, wr, 1'b1};
      return;
    end
    npd = pd | 32'h20;
    npt = pt | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (npd != pd) begin exp_q.push_back('{1'b1, pa, npd}); ref_mem[widx(pa)] = npd; end
    if (npt != pt) begin exp_q.push_back('{1'b1, pta, npt}); ref_mem[widx(pta)] = npt; end
    exp_paddr = {pt[31:12], va[11:0]};
    exp_attr = npt[8:0];
  endtask

  // memory with pseudo-random wait states, compared against the expected list each clock (R11)
  always @(negedge clk_i) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rst_ni && mem_valid_o && (lfsr[0] | lfsr[2])) begin
      op_t e;
      mem_ready_i = 1'b1;
      mem_rdata_i = mem[widx(mem_addr_o)];
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected memory op", mem_addr_o, 32'h0);
      end else begin
        e = exp_q.pop_front();
        check(mem_we_o == e.we, "R7", "op kind", 32'(mem_we_o), 32'(e.we));
        check(mem_addr_o == e.addr, e.we ? "R7" : "R2", "op address", mem_addr_o, e.addr);
        if (e.we) check(mem_wdata_o == e.data, "R8", "write data", mem_wdata_o, e.data);
      end
      if (mem_we_o) mem[widx(mem_addr_o)] = mem_wdata_o;
    end else begin
      mem_ready_i = 1'b0;
      mem_rdata_i = 32'h0;
    end
  end

  task automatic run_req(input logic [31:0] va, input logic [1:0] acc, input bit user,
                         input logic [19:0] base, input bit lgen, input string tag,
                         input bit junk);
    int n;
    model_walk(va, acc, user, base, lgen);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; req_acc_i = acc;
    req_user_i = user; root_base_i = base; large_en_i = lgen;
    @(negedge clk_i);
    check(busy_o == 1'b1, "R10", "busy after accept", 32'(busy_o), 32'h1);
    if (junk) begin
      req_vaddr_i = va ^ 32'h0040_0000; req_acc_i = 2'd1; root_base_i = 20'h0;
    end else begin
      req_valid_i = 1'b0;
    end
    n = 0;
    while (!rsp_valid_o && n < 2000) begin @(negedge clk_i); n++; end
    req_valid_i = 1'b0;
    check(rsp_valid_o == 1'b1, tag, "response seen", 32'(rsp_valid_o), 32'h1);
    check(rsp_fault_o == exp_fault, tag, "fault flag", 32'(rsp_fault_o), 32'(exp_fault));
    check(rsp_code_o == exp_code, exp_fault ? "R9" : "R4", "fault code",
          32'(rsp_code_o), 32'(exp_code));
    if (!exp_fault) begin
      check(rsp_paddr_o == exp_paddr, tag, "physical address", rsp_paddr_o, exp_paddr);
      check(rsp_attr_o == exp_attr, "R8", "attributes", 32'(rsp_attr_o), 32'(exp_attr));
    end
    check(exp_q.size() == 0, "R7", "all expected ops done", 32'(exp_q.size()), 32'h0);
    @(negedge clk_i);
    check(busy_o == 1'b0 && rsp_valid_o == 1'b0, "R10", "idle after response",
          {30'h0, busy_o, rsp_valid_o}, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int diff;
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    put(32'h1004, 32'h0000_2007);   // dir 1 -> table at 0x2000
    put(32'h200C, 32'h0ABC_D007);   // tbl 3
    put(32'h1008, 32'h0C80_0087);   // dir 2 large
    put(32'h1014, 32'h0000_3087);   // dir 5 large flag, frame 0x3000
    put(32'h3010, 32'h5555_5007);   // tbl at 0x3000 idx 4
    put(32'h101C, 32'h0000_2007);   // dir 7
    put(32'h1020, 32'h0000_2003);   // dir 8 supervisor only
    put(32'h1024, 32'h0400_0085);   // dir 9 large read-only
    put(32'h2028, 32'h4444_4003);   // tbl 10 supervisor only
    put(32'h202C, 32'h3333_3005);   // tbl 11 read-only
    put(32'h2030, 32'h1111_1E07);   // tbl 12 spare bits set
    put(32'h0004, 32'h0000_2007);   // second root, dir 1

    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0, "R12", "busy in reset", 32'(busy_o), 32'h0);
    check(mem_valid_o == 1'b0, "R12", "mem_valid in reset", 32'(mem_valid_o), 32'h0);
    check(rsp_valid_o == 1'b0, "R12", "rsp_valid in reset", 32'(rsp_valid_o), 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_req(32'h0040_3123, 2'd0, 1'b1, 20'h00001, 1'b0, "R2", 1'b0);  // first touch
    run_req(32'h0040_3123, 2'd1, 1'b1, 20'h00001, 1'b0, "R7", 1'b0);  // dirty only
    run_req(32'h0040_3123, 2'd0, 1'b1, 20'h00001, 1'b0, "R7", 1'b0);  // no writes
    run_req(32'h0081_2345, 2'd0, 1'b0, 20'h00001, 1'b1, "R3", 1'b0);  // large
    run_req(32'h0140_4456, 2'd0, 1'b0, 20'h00001, 1'b0, "R3", 1'b0);  // size flag ignored
    run_req(32'h0140_4456, 2'd0, 1'b0, 20'h00001, 1'b1, "R3", 1'b0);  // size flag honoured
    run_req(32'h0180_0000, 2'd1, 1'b1, 20'h00001, 1'b0, "R4", 1'b0);  // dir absent
    run_req(32'h01C0_9000, 2'd0, 1'b0, 20'h00001, 1'b0, "R4", 1'b0);  // tbl absent
    run_req(32'h0040_A000, 2'd0, 1'b1, 20'h00001, 1'b0, "R5", 1'b0);  // tbl not user
    run_req(32'h0200_3000, 2'd0, 1'b1, 20'h00001, 1'b0, "R5", 1'b0);  // dir not user
    run_req(32'h0040_B010, 2'd1, 1'b1, 20'h00001, 1'b0, "R6", 1'b0);  // user write ro
    run_req(32'h0040_B010, 2'd1, 1'b0, 20'h00001, 1'b0, "R6", 1'b0);  // sup write ro
    run_req(32'h0240_1000, 2'd1, 1'b1, 20'h00001, 1'b1, "R6", 1'b0);  // large user write ro
    run_req(32'h0240_1000, 2'd1, 1'b0, 20'h00001, 1'b1, "R6", 1'b0);  // large sup write
    run_req(32'h0040_C0FF, 2'd1, 1'b1, 20'h00001, 1'b0, "R8", 1'b0);  // spare bits
    run_req(32'h0040_3000, 2'd2, 1'b1, 20'h00001, 1'b0, "R9", 1'b0);  // fetch ok
    run_req(32'h0040_A000, 2'd2, 1'b1, 20'h00001, 1'b0, "R9", 1'b0);  // fetch fault
    run_req(32'h0040_3123, 2'd0, 1'b1, 20'h00000, 1'b0, "R1", 1'b0);  // other root
    run_req(32'h0040_3456, 2'd0, 1'b0, 20'h00001, 1'b0, "R10", 1'b1); // junk while busy

    diff = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) diff++;
    check(diff == 0, "R7", "final table contents", 32'(diff), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule